// File: doc/BRIEF.md
# Vertical-Blank Status Flag with Read-Clear Race

This block holds the vertical-blank status flag of a video display processor and presents it to a host CPU on one bit of a status register. A position compare produces a one-half-dot set pulse at the start of vertical blank, and a second one-half-dot pulse clears the flag at the start of the pre-render line. The CPU selects registers by decoding its read/write line and three address bits. That decode takes effect as soon as the bus cycle starts. The active-low chip enable is asserted only while the CPU bus clock is high.

A single internal strobe is high while the status register is read and the chip enable is low. That strobe does two jobs. It clears the flag, and it freezes a read latch which otherwise follows the flag. The CPU therefore sees the flag value from the moment the bus clock went high. Clearing takes priority over setting. A read whose high phase overlaps the set pulse loses the flag and the NMI it would have raised. A read that ends before the pulse does not affect the flag, and the flag sets normally.

The model is synchronous. Each cycle of `clk_i` is one pixel-clock half-cycle, and `pix_phase_i` marks which half it is. The NMI request is the flag gated by an enable bit and is driven active low. It holds no state of its own.

Top module: `vbl_status`

## Requirements
- R1: `rd_oe_o` is high exactly when `rw_i`=1 (read), `addr_i`=2 and `io_ce_ni`=0; reads of any other offset and any write leave it low.
- R2: During a status read, `rd_data_o` equals the flag value as it stands in the first cycle the strobe is high, and it holds that value for the whole time the strobe stays high.
- R3: A status read clears the flag, so a following status read returns 0 unless a set pulse occurs in between.
- R4: The flag sets when `vpos_i`=241, `hpos_i`=1 and `pix_phase_i`=0 while no status read strobe is active.
- R5: When the read strobe is high in the same cycle as the set pulse, the flag ends cleared and the NMI request is never asserted.
- R6: A status read whose strobe ends before the set pulse returns the old value and does not stop the flag from setting afterwards.
- R7: `nmi_no` is low exactly when the flag is set and `nmi_en_i`=1.
- R8: The flag clears when `vpos_i`=261, `hpos_i`=1 and `pix_phase_i`=0.
- R9: Asynchronous reset (`rst_ni`=0) clears the flag. After reset `nmi_no`=1, and `rd_oe_o` stays low while no read is in progress.
- R10: A write to offset 2, or a read of another offset, leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel half-cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_phase_i | input | 1 | 0 = first half of the dot, 1 = second half |
| vpos_i | input | 9 | Vertical position (scanline) |
| hpos_i | input | 9 | Horizontal position (dot) |
| rw_i | input | 1 | CPU read/write, 1 = read |
| addr_i | input | 3 | CPU register offset |
| io_ce_ni | input | 1 | Chip enable, active low, low during bus-clock high phase |
| nmi_en_i | input | 1 | NMI enable |
| rd_data_o | output | 1 | Status flag bit as seen by the CPU (data bit 7) |
| rd_oe_o | output | 1 | Drive enable for `rd_data_o`; low means high impedance |
| nmi_no | output | 1 | NMI request, active low |

## Verification
The bench moves a CPU read across the set dot one half-cycle at a time. It covers a read that fully precedes the pulse, one whose high phase covers the pulse, and one that starts just after it. Letting a set override a clear would make the NMI fire anyway in the overlap case. A latch that stayed transparent during the strobe would return 0 on the late read, because by then the strobe has already cleared the flag. The bench also checks that writes to offset 2 and reads of other offsets leave the flag intact, that the NMI is masked and then revealed by its enable bit, and that the pre-render clear works. A design that decoded sloppily, or that ignored the enable, would disturb or mask the flag where it should not.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  localparam int unsigned POS_W   = 9;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_REG = 1 << ADDR_W;

  typedef struct packed {
    logic [POS_W-1:0] line;
    logic [POS_W-1:0] dot;
  } pos_t;

  function automatic logic at_pos(pos_t p, int unsigned line, int unsigned dot, logic phase);
    return (p.line == POS_W'(line)) && (p.dot == POS_W'(dot)) && !phase;
  endfunction
endpackage

// File: rtl/vbl_sel_decode.sv
module vbl_sel_decode
  import vbl_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned NR = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rw_i,
  input  logic [AW-1:0] addr_i,
  output logic [NR-1:0] rd_sel_no
);
  // select lines are purely combinational: valid from the start of the bus cycle
  for (genvar g = 0; g < NR; g++) begin : g_sel
    assign rd_sel_no[g] = !(rw_i && (addr_i == AW'(g)));
  end

  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~rd_sel_no));
endmodule

// File: rtl/vbl_event_gen.sv
module vbl_event_gen
  import vbl_pkg::*;
#(
  parameter int unsigned SET_LINE = 241,
  parameter int unsigned SET_DOT  = 1,
  parameter int unsigned CLR_LINE = 261,
  parameter int unsigned CLR_DOT  = 1
) (
  input  logic pix_phase_i,
  input  pos_t pos_i,
  output logic set_o,
  output logic clr_o
);
  assign set_o = at_pos(pos_i, SET_LINE, SET_DOT, pix_phase_i);
  assign clr_o = at_pos(pos_i, CLR_LINE, CLR_DOT, pix_phase_i);
endmodule

// File: rtl/vbl_flag_latch.sv
module vbl_flag_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic line_clr_i,
  input  logic rd_strobe_i,
  output logic flag_o,
  output logic rd_val_o
);
  logic flag_q, flag_d, hold_q;

  // read strobe beats set, set beats line clear
  always_comb begin
    flag_d = flag_q;
    if (rd_strobe_i)     flag_d = 1'b0;
    else if (set_i)      flag_d = 1'b1;
    else if (line_clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (!rd_strobe_i) hold_q <= flag_d;
    end
  end

  assign flag_o   = flag_q;
  assign rd_val_o = rd_strobe_i ? hold_q : flag_q;

  assert_clr_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && set_i) |=> !flag_q);
  assert_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> !flag_q);
  assert_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !rd_strobe_i) |=> flag_q);
  assert_line_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_clr_i && !set_i) |=> !flag_q);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_strobe_i |=> (!rd_strobe_i || $stable(rd_val_o)));
endmodule

// File: rtl/vbl_status.sv
module vbl_status
  import vbl_pkg::*;
#(
  parameter int unsigned AW         = ADDR_W,
  parameter int unsigned STATUS_IDX = 2,
  parameter int unsigned SET_LINE   = 241,
  parameter int unsigned SET_DOT    = 1,
  parameter int unsigned CLR_LINE   = 261,
  parameter int unsigned CLR_DOT    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_phase_i,
  input  logic [POS_W-1:0] vpos_i,
  input  logic [POS_W-1:0] hpos_i,
  input  logic             rw_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             io_ce_ni,
  input  logic             nmi_en_i,
  output logic             rd_data_o,
  output logic             rd_oe_o,
  output logic             nmi_no
);
  localparam int unsigned NR = 1 << AW;

  logic [NR-1:0] rd_sel_n;
  logic set_p, clr_p, rd_strobe, flag, rd_val;
  pos_t pos;

  assign pos = '{line: vpos_i, dot: hpos_i};

  vbl_sel_decode #(.AW(AW)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .rw_i(rw_i), .addr_i(addr_i), .rd_sel_no(rd_sel_n)
  );

  vbl_event_gen #(
    .SET_LINE(SET_LINE), .SET_DOT(SET_DOT), .CLR_LINE(CLR_LINE), .CLR_DOT(CLR_DOT)
  ) u_evt (
    .pix_phase_i(pix_phase_i), .pos_i(pos), .set_o(set_p), .clr_o(clr_p)
  );

  // read-and-clear strobe: NOR of status select and chip enable, both active low
  assign rd_strobe = !(rd_sel_n[STATUS_IDX] || io_ce_ni);

  vbl_flag_latch u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_p), .line_clr_i(clr_p),
    .rd_strobe_i(rd_strobe), .flag_o(flag), .rd_val_o(rd_val)
  );

  assign rd_data_o = rd_val;
  assign rd_oe_o   = rd_strobe;
  assign nmi_no    = !(flag && nmi_en_i);

  assert_nmi_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_en_i |-> nmi_no);
  assert_oe_ce_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ce_ni |-> !rd_oe_o);
  assert_nmi_lost_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_oe_o && set_p) |=> nmi_no);
endmodule

// File: tb/sim_vbl_status.sv
module sim_vbl_status;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pix_phase = 1'b0, rw = 1'b1, ce_n = 1'b1, nmi_en = 1'b0;
  logic [8:0] vpos = '0, hpos = '0;
  logic [2:0] addr = '0;
  logic rd_data, rd_oe, nmi_n;

  int checks = 0, failures = 0;
  bit done = 0;
  int cur_v = 0, cur_h = 0;
  bit cur_ph = 0;
  bit m_flag = 0, m_hold = 0;
  bit last_rd, last_oe;

  always #10 clk = ~clk;

  vbl_status u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pix_phase_i(pix_phase), .vpos_i(vpos), .hpos_i(hpos),
    .rw_i(rw), .addr_i(addr), .io_ce_ni(ce_n), .nmi_en_i(nmi_en),
    .rd_data_o(rd_data), .rd_oe_o(rd_oe), .nmi_no(nmi_n)
  );

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // one pixel half-cycle; model updated at the edge, outputs compared mid-cycle
  task automatic half(input bit r, input bit [2:0] a, input bit c);
    bit strobe, setp, clrp, nf;
    rw = r; addr = a; ce_n = c; pix_phase = cur_ph;
    vpos = 9'(cur_v); hpos = 9'(cur_h);
    @(posedge clk);
    strobe = r && (a == 3'd2) && !c;
    setp = (cur_v == 241) && (cur_h == 1) && !cur_ph;
    clrp = (cur_v == 261) && (cur_h == 1) && !cur_ph;
    if (strobe) nf = 0; else if (setp) nf = 1; else if (clrp) nf = 0; else nf = m_flag;
    if (!strobe) m_hold = nf;
    m_flag = nf;
    @(negedge clk);
    chk(rd_oe, strobe, "R1 oe");
    chk(rd_data, strobe ? m_hold : m_flag, "R2 data");
    chk(nmi_n, !(m_flag && nmi_en), "R7 nmi");
    if (cur_ph) begin
      if (cur_h == 340) begin cur_h = 0; cur_v = (cur_v == 261) ? 0 : cur_v + 1; end
      else cur_h++;
    end
    cur_ph = ~cur_ph;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) half(1'b1, 3'd0, 1'b1);
  endtask

  // six half-cycles, bus clock high (ce low) for the last four
  task automatic cpu_cycle(input bit r, input bit [2:0] a);
    for (int k = 0; k < 6; k++) begin
      half(r, a, k < 2);
      if (k == 2) begin last_rd = rd_data; last_oe = rd_oe; end
    end
  endtask

  task automatic set_pos(input int v, input int h);
    cur_v = v; cur_h = h; cur_ph = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(nmi_n, 1'b1, "R9 nmi after reset");
    chk(rd_oe, 1'b0, "R9 oe after reset");
    rst_ni = 1'b1;
    nmi_en = 1'b1;
    idle(2);

    // read strobe ends before the set dot
    set_pos(240, 339);
    cpu_cycle(1, 3'd2);
    chk(last_oe, 1'b1, "R1 status read oe");
    chk(last_rd, 1'b0, "R6 early read value");
    idle(2);
    chk(nmi_n, 1'b0, "R6 flag set after early read");
    cpu_cycle(1, 3'd2);
    chk(last_rd, 1'b1, "R4 flag readback");
    cpu_cycle(1, 3'd2);
    chk(last_rd, 1'b0, "R3 cleared by read");

    // strobe covers the set dot
    set_pos(241, 0);
    cpu_cycle(1, 3'd2);
    chk(last_rd, 1'b0, "R5 overlap read value");
    idle(4);
    chk(nmi_n, 1'b1, "R5 nmi suppressed");
    cpu_cycle(1, 3'd2);
    chk(last_rd, 1'b0, "R5 flag lost");

    // read starts one half-cycle after the set dot
    set_pos(241, 0);
    idle(1);
    cpu_cycle(1, 3'd2);
    chk(last_rd, 1'b1, "R2 late read holds set value");
    cpu_cycle(1, 3'd2);
    chk(last_rd, 1'b0, "R3 late read cleared");

    // enable masking, writes and other offsets
    nmi_en = 1'b0;
    set_pos(241, 0);
    idle(6);
    chk(nmi_n, 1'b1, "R7 nmi masked");
    nmi_en = 1'b1;
    idle(1);
    chk(nmi_n, 1'b0, "R7 nmi unmasked");
    cpu_cycle(0, 3'd2);
    cpu_cycle(1, 3'd3);
    chk(last_oe, 1'b0, "R1 other offset no oe");
    chk(nmi_n, 1'b0, "R10 flag kept");
    cpu_cycle(1, 3'd2);
    chk(last_rd, 1'b1, "R10 flag survives write and other read");

    // pre-render line clear
    set_pos(241, 0);
    idle(4);
    chk(nmi_n, 1'b0, "R4 set again");
    set_pos(261, 0);
    idle(4);
    chk(nmi_n, 1'b1, "R8 line clear nmi");
    cpu_cycle(1, 3'd2);
    chk(last_rd, 1'b0, "R8 line clear read");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule